// File: doc/BRIEF.md
# Cascadable Serial Memory Bus Target

This block is the bus-facing target logic of a 2048-byte serial memory on a two-wire I2C bus. SCL and SDA are oversampled with the system clock, and the block recognises START and STOP conditions. It decodes the first byte of every transaction and acknowledges by pulling an open-drain SDA low. The array sits inside the block as a 2048 x 8 register file. The block services byte and multi-byte writes, random reads built from a dummy write followed by a repeated START, and current-address reads.

The first byte after a START does three jobs. It selects one of up to eight cascaded parts through three strap pins, one of which is matched in inverted form. It supplies the three upper bits of the 11-bit word address, and it gives the transfer direction. With all straps tied low the part behaves like a single non-cascaded device. A protect input turns the array read-only without changing the bus handshake.

Top module: `cascade_eeprom_slave`

## Requirements
- R1: Bus activity is ignored until a START is seen. A START is SDA falling while SCL is high. It restarts decoding of the first byte from any state and releases SDA.
- R2: A STOP is SDA rising while SCL is high. It returns the block to idle with SDA released. A byte sent after a STOP without a new START gets no acknowledge.
- R3: The first byte after a START is matched only when three conditions hold: bit 7 is 1; bits 6, 5 and 4 equal strap A2, the inverse of strap A1, and strap A0; and the remaining bits meet their own rules below. A matched byte is acknowledged by SDA low during the ninth clock. An unmatched byte gets no acknowledge and has no effect on memory.
- R4: In a write (bit 0 = 0), the next byte is word-address bits 7..0, and bits 3..1 of the first byte are word-address bits 10..8. Every later byte is acknowledged, stored at the pointer, and the pointer then advances.
- R5: The word pointer wraps from 0x7FF to 0x000, both on writes and on sequential reads.
- R6: While the protect input is high, data bytes are still acknowledged but memory does not change.
- R7: In a read (bit 0 = 1), the block drives the byte at the pointer MSB first. It changes SDA only while SCL is low. It sends the next sequential byte each time the master acknowledges.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START.
- R9: A repeated START keeps the word pointer, apart from bits 10..8, which the new first byte reloads. A write of the address followed by a repeated START and a read therefore returns data from that address.
- R10: During and directly after reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High to pull SDA low |
| sda_o | output | 1 | Value driven when enabled, always 0 (open drain) |
| strap_i | input | 3 | Chip-select straps A2, A1, A0 (bit 2 = A2) |
| wp_i | input | 1 | High makes the array read-only |

## Verification
The checker watches several rules on every cycle. A START always leads to first-byte decoding with SDA released. A STOP always leads to idle. Idle never drives SDA. The block only starts pulling SDA low while SCL is low, and no array write happens while protect is high. The bench scenarios cover what needs whole transactions and data values: the strap-and-code match sweep, address composition and wrap, read-back after protected writes, pointer retention across a repeated START, current-address reads, and silence after a master NACK or a STOP.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/cascade_eeprom_slave.sv
module cascade_eeprom_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       sda_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);
    localparam int HI_W = ADDR_W - BYTE_W;

    typedef struct packed {
        state_e              st;
        state_e              after;
        logic [BYTE_W-1:0]   sh;
        logic [3:0]          cnt;
        logic [ADDR_W-1:0]   ptr;
        logic                oe;
    } regs_t;

    regs_t r_q, r_d;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              mem_we;
    logic [BYTE_W-1:0] rd_data;
    logic              dev_match;

    eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
        .clk(clk), .we(mem_we), .waddr(r_q.ptr), .wdata(r_q.sh),
        .raddr(r_q.ptr), .rdata(rd_data)
    );

    // Select code: fixed one, then A2, inverted A1, A0.
    assign dev_match = r_q.sh[7] &&
                       (r_q.sh[6:4] == {strap_i[2], ~strap_i[1], strap_i[0]});

    always_comb begin
        r_d    = r_q;
        mem_we = 1'b0;
        if (start_det) begin
            r_d.st  = ST_DEV;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else if (stop_det) begin
            r_d.st  = ST_IDLE;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else begin
            case (r_q.st)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.cnt = '0;
                        case (r_q.st)
                            ST_DEV: begin
                                if (dev_match) begin
                                    r_d.ptr[ADDR_W-1:BYTE_W] = r_q.sh[HI_W:1];
                                    r_d.oe    = 1'b1;
                                    r_d.st    = ST_ACK;
                                    r_d.after = r_q.sh[0] ? ST_RDATA : ST_WADDR;
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end
                            ST_WADDR: begin
                                r_d.ptr[BYTE_W-1:0] = r_q.sh;
                                r_d.oe    = 1'b1;
                                r_d.st    = ST_ACK;
                                r_d.after = ST_WDATA;
                            end
                            default: begin
                                mem_we    = !wp_i;
                                r_d.ptr   = r_q.ptr + 1'b1;
                                r_d.oe    = 1'b1;
                                r_d.st    = ST_ACK;
                                r_d.after = ST_WDATA;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        r_d.st  = r_q.after;
                        if (r_q.after == ST_RDATA) begin
                            r_d.sh = rd_data;
                            r_d.oe = ~rd_data[BYTE_W-1];
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (r_q.cnt == 4'd7) begin
                            r_d.oe  = 1'b0;
                            r_d.cnt = '0;
                            r_d.st  = ST_RACK;
                            r_d.ptr = r_q.ptr + 1'b1;
                        end else begin
                            r_d.cnt = r_q.cnt + 4'd1;
                            r_d.sh  = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.oe  = ~r_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise && sda_s) begin
                        r_d.st = ST_IDLE;
                    end else if (scl_fall) begin
                        r_d.sh  = rd_data;
                        r_d.oe  = ~rd_data[BYTE_W-1];
                        r_d.cnt = '0;
                        r_d.st  = ST_RDATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, after: ST_IDLE, sh: '0, cnt: '0, ptr: '0, oe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe = r_q.oe;
    assign sda_o  = 1'b0;
endmodule

// File: rtl/eep_checker.sv
module eep_checker
    import eep_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   scl_s,
    input logic   start_det,
    input logic   stop_det,
    input state_e st,
    input logic   sda_oe,
    input logic   wp_i,
    input logic   mem_we
);
    assert_reset_release_R10: assert property (@(posedge clk)
        !rst_n |=> !sda_oe);

    assert_start_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_DEV && !sda_oe));

    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !sda_oe));

    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    assert_drive_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    assert_protect_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wp_i |-> !mem_we);
endmodule

bind cascade_eeprom_slave eep_checker u_checker (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .st(r_q.st), .sda_oe(sda_oe), .wp_i(wp_i),
    .mem_we(mem_we)
);

// File: tb/cascade_eeprom_slave_test.sv
module cascade_eeprom_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b000;
    logic       wp = 1'b0;
    logic       sda_oe, sda_o;
    logic       bus_sda;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    assign bus_sda = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_eeprom_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .sda_oe(sda_oe), .sda_o(sda_o), .strap_i(strap), .wp_i(wp)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b0; hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b1; hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hold();
            m_scl = 1'b1; hold(); hold();
            m_scl = 1'b0; hold();
        end
        m_sda = 1'b1; hold();
        m_scl = 1'b1; hold();
        ack = !bus_sda;
        hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit master_ack);
        b = '0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hold();
            m_scl = 1'b1; hold();
            b = {b[6:0], bus_sda};
            hold();
            m_scl = 1'b0;
        end
        hold();
        m_sda = !master_ack; hold();
        m_scl = 1'b1; hold(); hold();
        m_scl = 1'b0; hold();
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] pat(input int addr, input int seed);
        return 8'((addr * 13 + seed) & 255);
    endfunction

    function automatic logic [2:0] code_of(input logic [2:0] s);
        return {s[2], ~s[1], s[0]};
    endfunction

    task automatic write_run(input logic [2:0] code, input int addr, input int n,
                             input int seed, input bit exp_ack, input string req);
        bit ack;
        bus_start();
        send_byte({1'b1, code, 3'(addr >> 8), 1'b0}, ack);
        chk(ack == exp_ack, req, ack, exp_ack);
        if (ack) begin
            send_byte(8'(addr), ack);
            chk(ack, req, ack, 1);
            for (int k = 0; k < n; k++) begin
                send_byte(pat((addr + k) & 2047, seed), ack);
                chk(ack, req, ack, 1);
            end
        end
        bus_stop();
    endtask

    task automatic read_check(input int addr, input int n, input int seed, input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({1'b1, code_of(strap), 3'(addr >> 8), 1'b0}, ack);
        send_byte(8'(addr), ack);
        bus_start();
        send_byte({1'b1, code_of(strap), 3'(addr >> 8), 1'b1}, ack);
        chk(ack, req, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k != n - 1);
            chk(b == pat((addr + k) & 2047, seed), req, b, pat((addr + k) & 2047, seed));
        end
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0, "R10 reset", sda_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sda_oe == 1'b0, "R10 after reset", sda_oe, 0);

        // R1: a matching byte without START is ignored
        send_byte({1'b1, code_of(strap), 3'b000, 1'b0}, ack);
        chk(!ack, "R1 no start", ack, 0);

        // R3: strap and code sweep, plus MSB zero
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            for (int c = 0; c < 8; c++) begin
                bus_start();
                send_byte({1'b1, 3'(c), 3'b000, 1'b0}, ack);
                chk(ack == (3'(c) == code_of(3'(s))), "R3 match", ack,
                    int'(3'(c) == code_of(3'(s))));
                bus_stop();
            end
            bus_start();
            send_byte({1'b0, code_of(3'(s)), 3'b000, 1'b0}, ack);
            chk(!ack, "R3 msb zero", ack, 0);
            bus_stop();
        end

        // R4 + R9: write across the 0x3FF/0x400 boundary, random read back
        strap = 3'b101;
        write_run(code_of(strap), 12'h3F8, 16, 7, 1'b1, "R4 write");
        read_check(12'h3F8, 16, 7, "R9 R4 readback");

        // R5: wrap at the top of the array
        write_run(code_of(strap), 12'h7FE, 4, 3, 1'b1, "R5 write wrap");
        read_check(12'h7FE, 4, 3, "R5 read wrap");

        // R6: protected writes acknowledged, memory unchanged
        wp = 1'b1;
        write_run(code_of(strap), 12'h7FE, 4, 99, 1'b1, "R6 protected ack");
        wp = 1'b0;
        read_check(12'h7FE, 4, 3, "R6 unchanged");

        // R3: unmatched write leaves memory alone
        write_run(~code_of(strap), 12'h3F8, 2, 55, 1'b0, "R3 unmatched");
        read_check(12'h3F8, 2, 7, "R3 no effect");

        // R7: current-address read continues after one random-read byte
        read_check(12'h000, 1, 3, "R7 setup");
        bus_start();
        send_byte({1'b1, code_of(strap), 3'b000, 1'b1}, ack);
        chk(ack, "R7 current ack", ack, 1);
        recv_byte(b, 1'b0);
        chk(b == pat(1, 3), "R7 current addr", b, pat(1, 3));
        bus_stop();

        // R8: after master NACK the line stays released
        bus_start();
        send_byte({1'b1, code_of(strap), 3'b000, 1'b1}, ack);
        recv_byte(b, 1'b0);
        recv_byte(b, 1'b1);
        chk(b == 8'hFF, "R8 released", b, 8'hFF);
        bus_stop();

        // R2: after STOP a byte without START gets no acknowledge
        bus_start();
        send_byte({1'b1, code_of(strap), 3'b000, 1'b0}, ack);
        chk(ack, "R2 pre-stop ack", ack, 1);
        bus_stop();
        m_scl = 1'b0; hold();
        send_byte({1'b1, code_of(strap), 3'b000, 1'b0}, ack);
        chk(!ack, "R2 after stop", ack, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule